// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block collects interrupt requests from up to eighteen peripheral sources and turns them into a single vectored request to a CPU core. Each source can raise several pending flags, and any one of them makes the source request. A source is considered only when its own enable bit and the global enable are both set. Every source also carries an independent priority-level bit that places it in a high or a low level. Among the pending sources, the highest occupied level wins. Inside that level, the source with the lowest order number wins.

The winner's vector address is `VEC_BASE + VEC_STRIDE * order`, which gives 0x0003, 0x000B, and so on up to 0x008B at order 17. This address is presented together with a request line and stays frozen until the core accepts it. On acceptance the block marks the winner's level as in service. For a configurable subset of sources (by default the first four: both external lines and the two basic timers), it also sends a one-cycle clear pulse back to the source. All other flags are cleared by software at the peripheral.

A return-from-interrupt pulse ends the most deeply nested service. A high-level request may interrupt low-level service. Nothing interrupts high-level service, and low-level requests never interrupt each other. Order slot 16 is unused and can never request.

Top module: `pvic_top`

## Requirements
- R1: After reset, `irq_req` is 0, `flag_clr` is all zeros and no level is in service.
- R2: A source requests when any of its `SUB_W` flag bits (source s occupies bits `s*SUB_W` to `s*SUB_W+SUB_W-1` of `src_flags`) is 1 and its bit in `src_en` is 1. A source whose enable is 0 never requests.
- R3: While `global_en` is 0, `irq_req` never rises.
- R4: The presented vector equals 0x0003 + 8 * order of the winning source. Order 17 gives 0x008B.
- R5: A pending source whose `src_hi` bit is 1 wins over any pending source whose `src_hi` bit is 0, regardless of order.
- R6: Within one level, the pending source with the lowest order number wins.
- R7: Once `irq_req` is 1, it stays 1 and `irq_vec` stays unchanged until the first cycle in which `irq_ack` is 1. One clock after that cycle, `irq_req` is 0.
- R8: One clock after an accepted vector, `flag_clr` pulses the winner's bit for exactly one cycle, but only for orders 0 to 3. Other sources get no pulse.
- R9: During low-level service, a pending high-level source raises `irq_req`. A pending low-level source does not raise it until a return.
- R10: During high-level service, no source raises `irq_req`.
- R11: `irq_ret` ends high-level service if it is active, and ends low-level service otherwise.
- R12: Order 16 never requests, even with its flags and enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| global_en | input | 1 | Master enable for all sources |
| src_flags | input | NUM_SRC*SUB_W | Pending flags, SUB_W per source |
| src_en | input | NUM_SRC | Per-source enable |
| src_hi | input | NUM_SRC | Per-source level, 1 = high |
| irq_ack | input | 1 | Core accepts the presented vector |
| irq_ret | input | 1 | Core returns from a service routine |
| irq_req | output | 1 | Vectored request to the core |
| irq_vec | output | ADDR_W | Vector address of the winner |
| flag_clr | output | NUM_SRC | One-cycle hardware clear pulse per source |

## Verification
On every cycle, the assertions check the following: the held request and frozen vector until acceptance, that a request never rises without the global enable, that every presented vector lies on the vector grid of a populated slot, and that clear pulses are one-hot and follow only an acceptance. Arbitration outcomes are shown only by the bench's scenarios. These cover level-over-order selection, the lowest order winning inside a level, and preemption being allowed or refused depending on the level in service. The scenarios also cover which level a return releases and which sources receive a hardware clear.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   typedef enum logic {
      LVL_LO = 1'b0,
      LVL_HI = 1'b1
   } lvl_e;

   function automatic int clog2_min1(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pvic_src_gate.sv
module pvic_src_gate #(
   parameter int NUM_SRC = 18,
   parameter int SUB_W   = 8,
   parameter logic [NUM_SRC-1:0] PRESENT = '1
) (
   input  logic [NUM_SRC*SUB_W-1:0] src_flags,
   input  logic [NUM_SRC-1:0]       src_en,
   input  logic                     global_en,
   output logic [NUM_SRC-1:0]       pend
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      if (PRESENT[s]) begin : g_live
         assign pend[s] = global_en & src_en[s] & (|src_flags[s*SUB_W +: SUB_W]);
      end else begin : g_hole
         logic unused_flags;
         assign unused_flags = ^{src_flags[s*SUB_W +: SUB_W], src_en[s]};
         assign pend[s] = 1'b0;
      end
   end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
   import pvic_pkg::*;
#(
   parameter int NUM_SRC = 18,
   parameter int IDX_W   = clog2_min1(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] src_hi,
   output logic               any_pend,
   output logic [IDX_W-1:0]   win_idx,
   output lvl_e               win_lvl
);
   logic [NUM_SRC-1:0] hi_set;
   logic [NUM_SRC-1:0] pick_set;

   always_comb begin
      hi_set   = pend & src_hi;
      any_pend = |pend;
      if (|hi_set) begin
         pick_set = hi_set;
         win_lvl  = LVL_HI;
      end else begin
         pick_set = pend;
         win_lvl  = LVL_LO;
      end
   end

   always_comb begin
      win_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pick_set[i]) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/pvic_nest.sv
module pvic_nest
   import pvic_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  lvl_e take_lvl,
   input  logic ret,
   output logic in_hi,
   output logic in_lo
);
   logic nx_hi, nx_lo;

   always_comb begin
      nx_hi = in_hi;
      nx_lo = in_lo;
      if (ret) begin
         if (in_hi) nx_hi = 1'b0;
         else       nx_lo = 1'b0;
      end
      if (take) begin
         if (take_lvl == LVL_HI) nx_hi = 1'b1;
         else                    nx_lo = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_hi <= 1'b0;
         in_lo <= 1'b0;
      end else begin
         in_hi <= nx_hi;
         in_lo <= nx_lo;
      end
   end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
   import pvic_pkg::*;
#(
   parameter int NUM_SRC    = 18,
   parameter int SUB_W      = 8,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   parameter logic [NUM_SRC-1:0] PRESENT = 18'h2FFFF,
   parameter logic [NUM_SRC-1:0] AUTOCLR = 18'h0000F
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     global_en,
   input  logic [NUM_SRC*SUB_W-1:0] src_flags,
   input  logic [NUM_SRC-1:0]       src_en,
   input  logic [NUM_SRC-1:0]       src_hi,
   input  logic                     irq_ack,
   input  logic                     irq_ret,
   output logic                     irq_req,
   output logic [ADDR_W-1:0]        irq_vec,
   output logic [NUM_SRC-1:0]       flag_clr
);
   localparam int IDX_W   = clog2_min1(NUM_SRC);
   localparam int TOP_VEC = VEC_BASE + VEC_STRIDE * (NUM_SRC - 1);

   if (NUM_SRC < 1 || NUM_SRC > 64) begin : g_bad_num
      $error("pvic_top: NUM_SRC out of range");
   end
   if (SUB_W < 1) begin : g_bad_sub
      $error("pvic_top: SUB_W must be at least 1");
   end
   if (VEC_STRIDE < 1) begin : g_bad_stride
      $error("pvic_top: VEC_STRIDE must be at least 1");
   end
   if (TOP_VEC >= (2 ** ADDR_W)) begin : g_bad_addr
      $error("pvic_top: ADDR_W too narrow for vector table");
   end

   logic [NUM_SRC-1:0] pend;
   logic               any_pend;
   logic [IDX_W-1:0]   win_idx;
   lvl_e               win_lvl;
   logic               in_hi, in_lo;
   logic               may_raise;
   logic               take;
   logic [IDX_W-1:0]   held_idx;
   lvl_e               held_lvl;
   logic [NUM_SRC-1:0] clr_sel;

   pvic_src_gate #(
      .NUM_SRC (NUM_SRC),
      .SUB_W   (SUB_W),
      .PRESENT (PRESENT)
   ) u_gate (
      .src_flags (src_flags),
      .src_en    (src_en),
      .global_en (global_en),
      .pend      (pend)
   );

   pvic_arbiter #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W)
   ) u_arb (
      .pend     (pend),
      .src_hi   (src_hi),
      .any_pend (any_pend),
      .win_idx  (win_idx),
      .win_lvl  (win_lvl)
   );

   assign take = irq_req & irq_ack;

   pvic_nest u_nest (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .take_lvl (held_lvl),
      .ret      (irq_ret),
      .in_hi    (in_hi),
      .in_lo    (in_lo)
   );

   // preemption gate: high service blocks all, low service admits only high
   assign may_raise = any_pend & ~in_hi & (~in_lo | (win_lvl == LVL_HI));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req  <= 1'b0;
         irq_vec  <= '0;
         held_idx <= '0;
         held_lvl <= LVL_LO;
      end else if (irq_req) begin
         if (irq_ack) irq_req <= 1'b0;
      end else if (may_raise) begin
         irq_req  <= 1'b1;
         held_idx <= win_idx;
         held_lvl <= win_lvl;
         irq_vec  <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STRIDE) * ADDR_W'(win_idx);
      end
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_clr
      if (AUTOCLR[s]) begin : g_auto
         assign clr_sel[s] = take & (held_idx == IDX_W'(s));
      end else begin : g_soft
         assign clr_sel[s] = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flag_clr <= '0;
      else        flag_clr <= clr_sel;
   end
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
   parameter int NUM_SRC    = 18,
   parameter int ADDR_W     = 16,
   parameter int VEC_BASE   = 3,
   parameter int VEC_STRIDE = 8,
   parameter logic [NUM_SRC-1:0] PRESENT = '1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               global_en,
   input logic               irq_ack,
   input logic               irq_req,
   input logic [ADDR_W-1:0]  irq_vec,
   input logic [NUM_SRC-1:0] flag_clr
);
   int   rel;
   logic on_grid;

   always_comb begin
      rel     = int'(irq_vec) - VEC_BASE;
      on_grid = 1'b0;
      if (rel >= 0 && (rel % VEC_STRIDE) == 0 && (rel / VEC_STRIDE) < NUM_SRC)
         on_grid = PRESENT[rel / VEC_STRIDE];
   end

   // R7: request held with a frozen vector until accepted
   p_hold_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

   // R7: accepted request drops
   p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !irq_req);

   // R3: no rise without global enable
   p_glob_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_req) |-> $past(global_en));

   // R4 and R12: vector on the grid of a populated slot
   p_grid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> on_grid);

   // R8: at most one clear at a time
   p_clr_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(flag_clr));

   // R8: clear follows an acceptance
   p_clr_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|flag_clr) |-> $past(irq_req && irq_ack));
endmodule

bind pvic_top pvic_chk #(
   .NUM_SRC    (NUM_SRC),
   .ADDR_W     (ADDR_W),
   .VEC_BASE   (VEC_BASE),
   .VEC_STRIDE (VEC_STRIDE),
   .PRESENT    (PRESENT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .global_en (global_en),
   .irq_ack   (irq_ack),
   .irq_req   (irq_req),
   .irq_vec   (irq_vec),
   .flag_clr  (flag_clr)
);

// File: tb/pvic_top_tb_top.sv
module pvic_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NS = 18;
   localparam int SW = 8;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          global_en = 1'b0;
   logic [NS*SW-1:0] src_flags = '0;
   logic [NS-1:0] src_en = '0;
   logic [NS-1:0] src_hi = '0;
   logic          irq_ack = 1'b0;
   logic          irq_ret = 1'b0;
   logic          irq_req;
   logic [AW-1:0] irq_vec;
   logic [NS-1:0] flag_clr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   typedef struct { int src; string tag; } exp_t;
   exp_t sb[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pvic_top dut_i (
      .clk(clk), .rst_n(rst_n), .global_en(global_en), .src_flags(src_flags),
      .src_en(src_en), .src_hi(src_hi), .irq_ack(irq_ack), .irq_ret(irq_ret),
      .irq_req(irq_req), .irq_vec(irq_vec), .flag_clr(flag_clr)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic raise(input int s, input int sub, input bit hi);
      @(negedge clk);
      src_flags[s*SW + sub] = 1'b1;
      src_en[s] = 1'b1;
      src_hi[s] = hi;
   endtask

   task automatic drop(input int s);
      src_flags[s*SW +: SW] = '0;
   endtask

   task automatic expect_src(input int s, input string tag);
      exp_t e;
      e.src = s; e.tag = tag;
      sb.push_back(e);
   endtask

   // monitor step: wait for request, compare with scoreboard head, accept
   task automatic serve();
      exp_t e;
      int   n = 0;
      logic [NS-1:0] want;
      e = sb.pop_front();
      while (!irq_req && n < 6) begin @(negedge clk); n++; end
      chk(irq_req === 1'b1, {e.tag, " request"}, longint'(irq_req), 1);
      chk(irq_vec === AW'(3 + 8 * e.src), {e.tag, " vector R4"}, longint'(irq_vec), 3 + 8 * e.src);
      irq_ack = 1'b1;
      @(negedge clk);
      irq_ack = 1'b0;
      want = (e.src < 4) ? (NS'(1) << e.src) : '0;
      chk(flag_clr === want, {e.tag, " clear pulse R8"}, longint'(flag_clr), longint'(want));
      chk(irq_req === 1'b0, {e.tag, " drop R7"}, longint'(irq_req), 0);
      drop(e.src);
      @(negedge clk);
      chk(flag_clr === '0, {e.tag, " pulse width R8"}, longint'(flag_clr), 0);
   endtask

   task automatic quiet(input int cyc, input string tag);
      for (int i = 0; i < cyc; i++) begin
         @(negedge clk);
         chk(irq_req === 1'b0, tag, longint'(irq_req), 0);
      end
   endtask

   task automatic ret();
      @(negedge clk);
      irq_ret = 1'b1;
      @(negedge clk);
      irq_ret = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(irq_req === 1'b0, "R1 req after reset", longint'(irq_req), 0);
      chk(flag_clr === '0, "R1 clear after reset", longint'(flag_clr), 0);

      // R3: global enable off
      raise(0, 0, 0);
      quiet(3, "R3 global off");
      global_en = 1'b1;
      expect_src(0, "R2 ext0");
      serve(); ret();

      // R4 top slot, no auto clear
      raise(17, 5, 0);
      expect_src(17, "R4 order17");
      serve(); ret();

      // R12 unused slot
      raise(16, 0, 1);
      quiet(3, "R12 slot16");
      drop(16);

      // R2 enable off blocks, sub flag requests
      raise(4, 1, 0);
      src_en[4] = 1'b0;
      quiet(2, "R2 enable off");
      src_en[4] = 1'b1;
      expect_src(4, "R2 uart sub1");
      serve(); ret();

      // R6 lowest order within level, R9 low no preempt low
      raise(9, 2, 0);
      src_flags[5*SW + 0] = 1'b1; src_en[5] = 1'b1; src_hi[5] = 1'b0;
      expect_src(5, "R6 order5 over 9");
      serve();
      quiet(3, "R9 low blocks low");
      ret();
      expect_src(9, "R11 low after ret");
      serve(); ret();

      // R5 level over order, R10 hi blocks hi
      raise(2, 0, 0);
      src_flags[14*SW + 3] = 1'b1; src_en[14] = 1'b1; src_hi[14] = 1'b1;
      expect_src(14, "R5 hi 14 over low 2");
      serve();
      raise(1, 0, 1);
      quiet(3, "R10 hi blocks hi");
      ret();
      expect_src(1, "R10 after ret timer0");
      serve(); ret();
      expect_src(2, "R5 low ext1");
      serve(); ret();

      // R9 hi preempts low; R11 ret releases hi first
      raise(10, 4, 0);
      expect_src(10, "R9 low first");
      serve();
      raise(3, 0, 1);
      expect_src(3, "R9 hi preempts");
      serve();
      ret();
      raise(11, 0, 0);
      quiet(3, "R11 low still in service");
      ret();
      expect_src(11, "R11 after second ret");
      serve(); ret();

      // R7 stability while a higher source arrives
      raise(12, 0, 0);
      @(negedge clk);
      raise(0, 0, 1);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(irq_req === 1'b1 && irq_vec === AW'(3 + 8*12), "R7 frozen vector", longint'(irq_vec), 3 + 8*12);
      end
      expect_src(12, "R7 accept held");
      serve();
      expect_src(0, "R9 hi preempt after held");
      serve(); ret(); ret();
      quiet(2, "R1 idle at end");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      done = 1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule